// File: doc/BRIEF.md
# Byte-wise Multi-Polynomial CRC Engine

This block keeps a running cyclic redundancy code over a stream of bytes. Each byte is presented on an 8-bit input with a valid strobe. Each strobed byte is folded into the code register in one clock, so streams of any length can be protected. There is no length limit and no framing: the register simply accumulates until software clears it.

Software picks the generator polynomial and the bit order through a single control write. The polynomial is an 8-bit one or one of two 16-bit ones. The bit order is either most-significant-bit-first, which uses the plain polynomial and shifts the register left, or least-significant-bit-first, which uses the bit-reversed polynomial and shifts the register right. The same write can also zero the code register. The current code is always visible on the output, with the upper byte at zero whenever the 8-bit polynomial is active.

Top module: `bytecrc_engine`

## Requirements
- R1: After reset the code output is 0, polynomial code 0 is selected and the order is most-significant-bit-first, so bytes sent without any control write use that setting.
- R2: Polynomial code 0 is x^8+x^2+x+1 (8-bit register). With a zero start and MSB-first order, the ASCII bytes "123456789" give 0x00F4.
- R3: Polynomial code 1 is x^16+x^15+x^2+1. With a zero start, "123456789" gives 0xFEE8 MSB-first and 0xBB3D LSB-first.
- R4: Polynomial code 2 is x^16+x^12+x^5+1. With a zero start, "123456789" gives 0x31C3 MSB-first and 0x2189 LSB-first.
- R5: Order bit 0 feeds byte bit 7 first into a left-shifting register with the plain polynomial. Order bit 1 feeds byte bit 0 first into a right-shifting register with the bit-reversed polynomial. This holds for every polynomial code, including the 8-bit one.
- R6: A byte strobed on a clock edge is fully folded in by that edge and readable right after it. Cycles without a strobe and without a control write leave the output unchanged.
- R7: A control write with the clear bit set zeroes the code. A control write without it keeps the code, cut to the new polynomial's width.
- R8: While polynomial code 0 is active, output bits 15:8 read 0. This includes after a switch from a 16-bit code without a clear.
- R9: When a control write and a byte strobe share a cycle, the control write (selection and clear) takes effect first and the byte is folded in under the new setting.
- R10: A control write carrying polynomial code 3 is ignored completely. The selection, the order and the code are all unchanged, even if the clear bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_poly | input | 2 | Polynomial code: 0 = 8-bit, 1 and 2 = 16-bit, 3 = reserved |
| ctl_lsb_first | input | 1 | Bit order: 1 = LSB-first (reflected), 0 = MSB-first |
| ctl_clear | input | 1 | Zero the code register with this control write |
| data_valid | input | 1 | Byte strobe |
| data_byte | input | DATA_W (8) | Byte to fold in |
| crc_value | output | CRC_W (16) | Current code register |

## Verification
The bench builds the engine with its default sizes, an 8-bit data path and a 16-bit register. These widths let every one of the three polynomials be checked against published check values for the nine-byte ASCII string, in both orders where a value exists. They also let a bit-serial bench model follow byte-by-byte updates, width truncation when the mode changes, and the reflected 8-bit case. With the 16-bit register, the switch from a 16-bit code to the 8-bit one shows whether the upper byte is really cleared. Same-cycle control and data writes show the stated ordering, and the reserved code is shown to be ignored.

// File: rtl/crcb_pkg.sv
package crcb_pkg;

   // Polynomial selection codes seen on the control port
   typedef enum logic [1:0] {
      POLY_C8  = 2'd0,
      POLY_A16 = 2'd1,
      POLY_B16 = 2'd2,
      POLY_RSV = 2'd3
   } poly_sel_e;

   localparam int unsigned NUM_POLY  = 3;
   localparam int unsigned MAX_POLYW = 16;

   // Register width used by polynomial index i
   function automatic int unsigned poly_width(input int unsigned idx);
      case (idx)
         0:       poly_width = 8;
         default: poly_width = 16;
      endcase
   endfunction

   // Generator in plain (non-reflected) form, implicit top term dropped
   function automatic logic [31:0] poly_plain(input int unsigned idx);
      case (idx)
         0:       poly_plain = 32'h0000_0007;
         1:       poly_plain = 32'h0000_8005;
         default: poly_plain = 32'h0000_1021;
      endcase
   endfunction

   // Bit-reverse the low w bits of v
   function automatic logic [31:0] bit_reverse(input logic [31:0] v, input int unsigned w);
      logic [31:0] r;
      r = '0;
      for (int unsigned k = 0; k < w; k++) r[k] = v[w-1-k];
      return r;
   endfunction

   // Mask that keeps only the bits belonging to a selection code
   function automatic logic [31:0] width_mask(input logic [1:0] sel);
      int unsigned w;
      w = poly_width(int'(sel));
      return (32'h1 << w) - 32'h1;
   endfunction

endpackage

// File: rtl/crcb_ctl.sv
module crcb_ctl
   import crcb_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [1:0]          sel_in,
   input  logic                lsb_in,
   input  logic                clear_in,
   output logic [1:0]          sel_q,
   output logic                lsb_q,
   output logic [1:0]          eff_sel,
   output logic                eff_lsb,
   output logic                accept,
   output logic                clr,
   output logic [NUM_POLY-1:0] poly_oh
);

   // The reserved code makes the whole write vanish
   assign accept  = we && (sel_in != POLY_RSV);
   assign clr     = accept && clear_in;
   assign eff_sel = accept ? sel_in : sel_q;
   assign eff_lsb = accept ? lsb_in : lsb_q;

   for (genvar gi = 0; gi < NUM_POLY; gi++) begin : g_oh
      assign poly_oh[gi] = (eff_sel == 2'(gi));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= POLY_C8;
         lsb_q <= 1'b0;
      end else if (accept) begin
         sel_q <= sel_in;
         lsb_q <= lsb_in;
      end
   end

   AST_RSV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel_in == POLY_RSV) |=> ($stable(sel_q) && $stable(lsb_q))); // R10

   AST_SEL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q != POLY_RSV); // R10

   AST_ONE_POLY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(poly_oh) && (poly_oh != '0)); // R5

endmodule

// File: rtl/crcb_step.sv
module crcb_step #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned W      = 16,
   parameter logic [31:0] POLY   = 32'h0000_1021
) (
   input  logic [W-1:0]      cur,
   input  logic [DATA_W-1:0] din,
   input  logic              lsb_first,
   output logic [W-1:0]      nxt
);
   import crcb_pkg::*;

   localparam logic [W-1:0] P_PLAIN = POLY[W-1:0];
   localparam logic [31:0]  P_REV32 = bit_reverse(POLY, W);
   localparam logic [W-1:0] P_REV   = P_REV32[W-1:0];

   if (W < 2 || W > 32) begin : g_bad_w
      $error("crcb_step: register width out of range");
   end

   logic [W-1:0] left_r;
   logic [W-1:0] right_r;

   // Left-shifting form: byte enters from its top bit
   always_comb begin
      logic fb;
      left_r = cur;
      for (int i = int'(DATA_W) - 1; i >= 0; i--) begin
         fb     = left_r[W-1] ^ din[i];
         left_r = {left_r[W-2:0], 1'b0} ^ (fb ? P_PLAIN : '0);
      end
   end

   // Right-shifting reflected form: byte enters from its bottom bit
   always_comb begin
      logic fb;
      right_r = cur;
      for (int i = 0; i < int'(DATA_W); i++) begin
         fb      = right_r[0] ^ din[i];
         right_r = {1'b0, right_r[W-1:1]} ^ (fb ? P_REV : '0);
      end
   end

   assign nxt = lsb_first ? right_r : left_r;

endmodule

// File: rtl/bytecrc_engine.sv
module bytecrc_engine
   import crcb_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CRC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [1:0]        ctl_poly,
   input  logic              ctl_lsb_first,
   input  logic              ctl_clear,
   input  logic              data_valid,
   input  logic [DATA_W-1:0] data_byte,
   output logic [CRC_W-1:0]  crc_value
);

   localparam logic [CRC_W-1:0] ZERO_CODE = '0;

   if (CRC_W < MAX_POLYW || CRC_W > 32) begin : g_bad_crc_w
      $error("bytecrc_engine: CRC_W must hold the widest polynomial");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_data_w
      $error("bytecrc_engine: DATA_W out of range");
   end

   logic [1:0]          sel_q, eff_sel;
   logic                lsb_q, eff_lsb, accept, clr;
   logic [NUM_POLY-1:0] poly_oh;
   logic [CRC_W-1:0]    crc_q, base, folded, crc_d;
   logic [CRC_W-1:0]    step_ext [NUM_POLY];

   crcb_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (ctl_we),
      .sel_in   (ctl_poly),
      .lsb_in   (ctl_lsb_first),
      .clear_in (ctl_clear),
      .sel_q    (sel_q),
      .lsb_q    (lsb_q),
      .eff_sel  (eff_sel),
      .eff_lsb  (eff_lsb),
      .accept   (accept),
      .clr      (clr),
      .poly_oh  (poly_oh)
   );

   // Control write applies before the byte of the same cycle
   always_comb begin
      logic [31:0] msk;
      msk = width_mask(eff_sel);
      if (clr)         base = ZERO_CODE;
      else if (accept) base = crc_q & msk[CRC_W-1:0];
      else             base = crc_q;
   end

   // One byte-step per polynomial; each sees only its own width
   for (genvar gp = 0; gp < NUM_POLY; gp++) begin : g_poly
      localparam int unsigned PW = poly_width(gp);
      logic [PW-1:0] s_out;
      crcb_step #(
         .DATA_W (DATA_W),
         .W      (PW),
         .POLY   (poly_plain(gp))
      ) u_step (
         .cur       (base[PW-1:0]),
         .din       (data_byte),
         .lsb_first (eff_lsb),
         .nxt       (s_out)
      );
      if (PW == CRC_W) begin : g_full
         assign step_ext[gp] = s_out;
      end else begin : g_ext
         assign step_ext[gp] = {{(CRC_W-PW){1'b0}}, s_out};
      end
   end

   always_comb begin
      folded = '0;
      for (int i = 0; i < int'(NUM_POLY); i++)
         folded |= step_ext[i] & {CRC_W{poly_oh[i]}};
   end

   assign crc_d = data_valid ? folded : base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) crc_q <= '0;
      else        crc_q <= crc_d;
   end

   assign crc_value = crc_q;

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we && !data_valid) |=> $stable(crc_value)); // R6

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_clear && ctl_poly != POLY_RSV && !data_valid) |=> (crc_value == '0)); // R7

   AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q == POLY_C8) |-> (crc_q[CRC_W-1:8] == '0)); // R8

   AST_RSV_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_poly == POLY_RSV && !data_valid) |=> $stable(crc_value)); // R10

   AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_we) |=> $stable(lsb_q)); // R5

endmodule

// File: tb/bytecrc_engine_bench.sv
module bytecrc_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [1:0]  ctl_poly = 2'd0;
   logic        ctl_lsb_first = 1'b0;
   logic        ctl_clear = 1'b0;
   logic        data_valid = 1'b0;
   logic [7:0]  data_byte = 8'h00;
   logic [15:0] crc_value;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bytecrc_engine u_bytecrc_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_we        (ctl_we),
      .ctl_poly      (ctl_poly),
      .ctl_lsb_first (ctl_lsb_first),
      .ctl_clear     (ctl_clear),
      .data_valid    (data_valid),
      .data_byte     (data_byte),
      .crc_value     (crc_value)
   );

   // Bit-serial model written from the requirement text
   function automatic logic [15:0] model(input logic [1:0] s, input logic lsb,
                                         input logic [15:0] c, input logic [7:0] b);
      int          w;
      logic [15:0] g, gr, m;
      logic        bit_out;
      w  = (s == 2'd0) ? 8 : 16;
      g  = (s == 2'd0) ? 16'h0007 : (s == 2'd1) ? 16'h8005 : 16'h1021;
      m  = (w == 8) ? 16'h00FF : 16'hFFFF;
      gr = '0;
      for (int k = 0; k < w; k++) gr[k] = g[w-1-k];
      c = c & m;
      if (!lsb) begin
         for (int i = 7; i >= 0; i--) begin
            bit_out = c[w-1];
            c = (c << 1) & m;
            if (bit_out != b[i]) c = c ^ g;
         end
      end else begin
         for (int i = 0; i < 8; i++) begin
            bit_out = c[0];
            c = c >> 1;
            if (bit_out != b[i]) c = c ^ gr;
         end
      end
      return c;
   endfunction

   task automatic check(input string req, input logic [15:0] exp);
      n_run++;
      if (crc_value !== exp) begin
         n_fail++;
         $display("FAIL %s: crc_value=%h expected=%h", req, crc_value, exp);
      end
   endtask

   task automatic ctl_write(input logic [1:0] s, input logic lsb, input logic clr);
      ctl_we = 1'b1; ctl_poly = s; ctl_lsb_first = lsb; ctl_clear = clr;
      @(negedge clk);
      ctl_we = 1'b0; ctl_clear = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      data_valid = 1'b1; data_byte = b;
      @(negedge clk);
      data_valid = 1'b0;
   endtask

   task automatic send_digits();
      for (int i = 0; i < 9; i++) send(8'h31 + 8'(i));
   endtask

   task automatic t_reset();
      check("R1 reset value", 16'h0000);
      send_digits();
      check("R1 default mode", 16'h00F4);
   endtask

   task automatic t_vector(input logic [1:0] s, input logic lsb,
                           input logic [15:0] exp, input string req);
      logic [15:0] m;
      ctl_write(s, lsb, 1'b1);
      check("R7 clear before vector", 16'h0000);
      send_digits();
      check(req, exp);
      m = 16'h0000;
      for (int i = 0; i < 9; i++) m = model(s, lsb, m, 8'h31 + 8'(i));
      check("R5 model agrees", m);
   endtask

   task automatic t_per_byte();
      logic [15:0] m;
      ctl_write(2'd2, 1'b0, 1'b1);
      m = 16'h0000;
      for (int i = 0; i < 4; i++) begin
         logic [7:0] b;
         b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'hA5 : 8'h5A;
         send(b);
         m = model(2'd2, 1'b0, m, b);
         check("R6 per-byte update", m);
      end
      for (int i = 0; i < 3; i++) @(negedge clk);
      check("R6 idle hold", m);
   endtask

   task automatic t_reflected8();
      logic [15:0] m;
      ctl_write(2'd0, 1'b1, 1'b1);
      m = 16'h0000;
      for (int i = 0; i < 5; i++) begin
         send(8'h80 >> i);
         m = model(2'd0, 1'b1, m, 8'h80 >> i);
      end
      check("R5 reflected 8-bit", m);
   endtask

   task automatic t_clear_keep();
      logic [15:0] v;
      ctl_write(2'd1, 1'b0, 1'b1);
      send(8'hC3); send(8'h3C);
      v = model(2'd1, 1'b0, model(2'd1, 1'b0, 16'h0000, 8'hC3), 8'h3C);
      check("R7 value before", v);
      ctl_write(2'd2, 1'b0, 1'b0);
      check("R7 keep without clear", v);
      ctl_write(2'd2, 1'b0, 1'b1);
      check("R7 clear zeroes", 16'h0000);
   endtask

   task automatic t_narrow();
      logic [15:0] v;
      ctl_write(2'd1, 1'b1, 1'b1);
      send(8'h12); send(8'h34);
      v = model(2'd1, 1'b1, model(2'd1, 1'b1, 16'h0000, 8'h12), 8'h34);
      check("R8 16-bit value", v);
      ctl_write(2'd0, 1'b0, 1'b0);
      check("R8 upper byte zero after switch", v & 16'h00FF);
      send(8'h77);
      check("R8 8-bit fold after switch", model(2'd0, 1'b0, v & 16'h00FF, 8'h77));
   endtask

   task automatic t_same_cycle();
      ctl_write(2'd1, 1'b0, 1'b1);
      send(8'h99);
      ctl_we = 1'b1; ctl_poly = 2'd2; ctl_lsb_first = 1'b1; ctl_clear = 1'b1;
      data_valid = 1'b1; data_byte = 8'h31;
      @(negedge clk);
      ctl_we = 1'b0; ctl_clear = 1'b0; data_valid = 1'b0;
      check("R9 control before byte", model(2'd2, 1'b1, 16'h0000, 8'h31));
   endtask

   task automatic t_reserved();
      logic [15:0] v;
      ctl_write(2'd2, 1'b0, 1'b1);
      send(8'h42);
      v = model(2'd2, 1'b0, 16'h0000, 8'h42);
      ctl_write(2'd3, 1'b1, 1'b1);
      check("R10 reserved write keeps code", v);
      send(8'h24);
      check("R10 mode unchanged", model(2'd2, 1'b0, v, 8'h24));
   endtask

   initial begin
      for (int i = 0; i < 3; i++) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_vector(2'd0, 1'b0, 16'h00F4, "R2 8-bit check value");
      t_vector(2'd1, 1'b0, 16'hFEE8, "R3 MSB-first check value");
      t_vector(2'd1, 1'b1, 16'hBB3D, "R3 LSB-first check value");
      t_vector(2'd2, 1'b0, 16'h31C3, "R4 MSB-first check value");
      t_vector(2'd2, 1'b1, 16'h2189, "R4 LSB-first check value");
      t_per_byte();
      t_reflected8();
      t_clear_keep();
      t_narrow();
      t_same_cycle();
      t_reserved();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule